// File: doc/BRIEF.md
# Branch Program-Counter Trace Buffer

This block keeps a rolling history of the program counter of every taken branch in a small microcontroller, so that after a hang or crash a host can find out where execution had been. Each cycle in which the core reports a taken branch, the branch PC is written into a circular store of `DEPTH` entries. When the store is full, the oldest record is overwritten. No branch is ever dropped.

The host sees two registers. The index register holds a writable selector and a read-only field that reports how many records are valid. The trace register returns the record chosen by the selector. Selector value 0 is the newest branch, and larger values walk back in time. While the core runs in its high-security mode, both the count field and the trace register read as zero so that no history leaks. Recording carries on during that time.

The branch input is a plain strobe and never back-pressures the core. The host side is a register port with a combinational read.

Top module: `brtrace_top`

## Requirements
- R1: After reset, the index register (address 0) reads 0 and the trace register (address 1) reads 0.
- R2: Each cycle with `br_valid` high adds one to the valid count, which reads back in bits [21:16] of the index register. The count is unchanged in cycles without a branch.
- R3: The trace register returns the PC in bits [23:0], with bits [31:24] zero. Selector value 0 gives the most recent branch, and selector k gives the branch recorded k branches before it.
- R4: When the store already holds `DEPTH` (32) records, a new branch replaces the oldest one, and the count stays at 32.
- R5: A host write to address 0 loads bits [5:0] of the write data into the selector, which reads back in bits [5:0]. The other write bits are ignored, including those over the count field.
- R6: When the selector value is at or above the valid count, the trace register reads 0.
- R7: While `sec_mode` is high, the trace register and the count field read 0, and branches are still recorded.
- R8: A host read in the same cycle as a branch returns the state from before that branch.
- R9: A host write to address 1 changes neither the selector, the count nor the stored records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | Taken-branch strobe, one record per high cycle |
| br_pc | input | 24 | PC of the taken branch |
| sec_mode | input | 1 | High-security mode; blanks the readout |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 1 | Register select: 0 index, 1 trace |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr`, combinational |

## Verification
The assertions assume that `br_pc` and `host_addr` are driven to known values in every cycle, and that `sec_mode` changes only between clock edges. They take nothing for granted about how often branches arrive or about the order of host accesses. The bench changes every input just after a falling edge and holds it through the next rising edge. It uses only the two defined addresses and writes selector values above 31 on purpose, to reach the out-of-range path.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned CNT_LSB = 16;
  typedef enum logic {ADDR_INDEX = 1'b0, ADDR_TRACE = 1'b1} reg_addr_e;
endpackage

// File: rtl/brtrace_store.sv
module brtrace_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned PC_W  = 24,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [PC_W-1:0]  push_pc,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [PC_W-1:0]  rd_pc,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [CNT_W-1:0] count
);
  logic [PC_W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= push_pc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      count  <= '0;
    end else if (push) begin
      wr_ptr <= wr_ptr + PTR_W'(1);
      if (count != CNT_W'(DEPTH)) count <= count + CNT_W'(1);
    end
  end

  assign rd_pc = slots[rd_ptr];
endmodule

// File: rtl/brtrace_view.sv
module brtrace_view #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned PC_W  = 24,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] sel,
  input  logic [CNT_W-1:0] count,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic             blank,
  input  logic [PC_W-1:0]  slot_pc,
  output logic [PTR_W-1:0] slot_ptr,
  output logic [PC_W-1:0]  view_pc,
  output logic [CNT_W-1:0] view_cnt
);
  logic in_range;

  // newest record sits one slot behind the write pointer; wraps modulo DEPTH
  assign slot_ptr = wr_ptr - PTR_W'(1) - sel[PTR_W-1:0];
  assign in_range = sel < count;
  assign view_pc  = (in_range && !blank) ? slot_pc : '0;
  assign view_cnt = blank ? '0 : count;
endmodule

// File: rtl/brtrace_top.sv
module brtrace_top
  import brtrace_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned PC_W  = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [PC_W-1:0]  br_pc,
  input  logic             sec_mode,
  input  logic             host_wr,
  input  logic             host_addr,
  input  logic [REG_W-1:0] host_wdata,
  output logic [REG_W-1:0] host_rdata
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] sel_q;
  logic [CNT_W-1:0] trace_cnt;
  logic [CNT_W-1:0] vis_cnt;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] slot_ptr;
  logic [PC_W-1:0]  slot_pc;
  logic [PC_W-1:0]  vis_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else if (host_wr && reg_addr_e'(host_addr) == ADDR_INDEX)
      sel_q <= host_wdata[CNT_W-1:0];
  end

  brtrace_store #(.DEPTH(DEPTH), .PC_W(PC_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (br_valid),
    .push_pc(br_pc),
    .rd_ptr (slot_ptr),
    .rd_pc  (slot_pc),
    .wr_ptr (wr_ptr),
    .count  (trace_cnt)
  );

  brtrace_view #(.DEPTH(DEPTH), .PC_W(PC_W)) u_view (
    .sel     (sel_q),
    .count   (trace_cnt),
    .wr_ptr  (wr_ptr),
    .blank   (sec_mode),
    .slot_pc (slot_pc),
    .slot_ptr(slot_ptr),
    .view_pc (vis_pc),
    .view_cnt(vis_cnt)
  );

  always_comb begin
    if (reg_addr_e'(host_addr) == ADDR_INDEX)
      host_rdata = (REG_W'(vis_cnt) << CNT_LSB) | REG_W'(sel_q);
    else
      host_rdata = REG_W'(vis_pc);
  end
endmodule

// File: rtl/brtrace_chk.sv
module brtrace_chk #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned PC_W  = 24,
  parameter int unsigned REG_W = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             br_valid,
  input logic [PC_W-1:0]  br_pc,
  input logic             sec_mode,
  input logic             host_wr,
  input logic             host_addr,
  input logic [REG_W-1:0] host_rdata,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] sel
);
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && cnt < CNT_W'(DEPTH)) |=> cnt == $past(cnt) + CNT_W'(1));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> $stable(cnt));

  p_count_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && cnt == CNT_W'(DEPTH)) |=> cnt == CNT_W'(DEPTH));

  p_oob_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr && sel >= cnt) |-> host_rdata == '0);

  p_sec_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_mode && host_addr) |-> host_rdata == '0);

  p_sec_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_mode && !host_addr) |-> host_rdata[CNT_W+15:16] == '0);

  p_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !host_wr) |=>
      (!(host_addr && !sec_mode && sel == '0) ||
       host_rdata == {{(REG_W-PC_W){1'b0}}, $past(br_pc)}));
endmodule

bind brtrace_top brtrace_chk #(.DEPTH(DEPTH), .PC_W(PC_W), .REG_W(brtrace_pkg::REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .br_valid  (br_valid),
  .br_pc     (br_pc),
  .sec_mode  (sec_mode),
  .host_wr   (host_wr),
  .host_addr (host_addr),
  .host_rdata(host_rdata),
  .cnt       (trace_cnt),
  .sel       (sel_q)
);

// File: tb/brtrace_top_tb.sv
`timescale 1ns/1ps
module brtrace_top_tb;
  localparam int DEPTH = 32;
  localparam int PC_W  = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 1'b0;
  logic [23:0] br_pc = '0;
  logic        sec_mode = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_addr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int hist[$];
  int m_sel = 0;

  always #2.5 clk = ~clk;

  brtrace_top #(.DEPTH(DEPTH), .PC_W(PC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pc(br_pc),
    .sec_mode(sec_mode), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  function automatic logic [31:0] model_read(bit a, bit sec);
    if (!a) return ((sec ? 32'd0 : 32'(hist.size())) << 16) | 32'(m_sel);
    if (sec || m_sel >= hist.size()) return 32'd0;
    return 32'(hist[m_sel]);
  endfunction

  task automatic step(string tag, bit br, int pc, bit wr, bit a, logic [31:0] wd, bit sec);
    logic [31:0] exp;
    @(negedge clk);
    br_valid = br; br_pc = pc[23:0]; host_wr = wr; host_addr = a;
    host_wdata = wd; sec_mode = sec;
    #1;
    exp = model_read(a, sec);
    n_cmp++;
    if (host_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: addr=%0d actual=%h expected=%h", tag, a, host_rdata, exp);
    end
    @(posedge clk);
    if (br) begin
      hist.push_front(pc & 24'hFFFFFF);
      if (hist.size() > DEPTH) void'(hist.pop_back());
    end
    if (wr && !a) m_sel = int'(wd[5:0]);
  endtask

  function automatic int pcv(int i);
    return (32'h00A000 + i * 32'h1357) & 32'hFFFFFF;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 0, 0);
    step("R1", 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 5; i++) step("R2", 1, pcv(i), 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0);
    for (int s = 0; s < 5; s++) begin
      step("R5", 0, 0, 1, 0, 32'(s), 0);
      step("R3", 0, 0, 0, 1, 0, 0);
    end
    for (int s = 5; s < 8; s++) begin
      step("R5", 0, 0, 1, 0, 32'(s), 0);
      step("R6", 0, 0, 0, 1, 0, 0);
    end
    step("R5", 0, 0, 1, 0, 32'h0, 0);
    step("R8", 1, pcv(100), 0, 1, 0, 0);
    step("R8", 1, pcv(101), 0, 0, 0, 0);
    step("R3", 0, 0, 0, 1, 0, 0);
    step("R9", 0, 0, 1, 1, 32'hFFFF_FF3F, 0);
    step("R9", 0, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 1, 0, 0);
    step("R5", 0, 0, 1, 0, 32'hFFFF_FFC3, 0);
    step("R5", 0, 0, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < 40; i++) step("R4", 1, pcv(200 + i), 0, i % 2, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 0);
    for (int s = 0; s < 32; s += 7) begin
      step("R5", 0, 0, 1, 0, 32'(s), 0);
      step("R4", 0, 0, 0, 1, 0, 0);
    end
    step("R5", 0, 0, 1, 0, 32'd31, 0);
    step("R4", 0, 0, 0, 1, 0, 0);
    step("R5", 0, 0, 1, 0, 32'd32, 0);
    step("R6", 0, 0, 0, 1, 0, 0);
    step("R5", 0, 0, 1, 0, 32'd63, 0);
    step("R6", 0, 0, 0, 1, 0, 0);
    step("R5", 0, 0, 1, 0, 32'd0, 0);
    for (int i = 0; i < 3; i++) step("R7", 1, pcv(300 + i), 0, i % 2, 0, 1);
    step("R7", 0, 0, 0, 0, 0, 1);
    step("R7", 0, 0, 0, 1, 0, 1);
    step("R7", 0, 0, 0, 1, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 0);
    step("R5", 0, 0, 1, 0, 32'd2, 0);
    step("R7", 0, 0, 0, 1, 0, 0);
    @(negedge clk); rst_n = 1'b0; br_valid = 0; host_wr = 0;
    @(posedge clk);
    hist.delete(); m_sel = 0;
    @(negedge clk); rst_n = 1'b1;
    step("R1", 0, 0, 0, 0, 0, 0);
    step("R1", 0, 0, 0, 1, 0, 0);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule